// File: doc/BRIEF.md
# Programmable SCL Period Generator

This block produces the clock waveform of a two-wire bus master. It alternates between a low phase, during which it pulls SCL down, and a high phase, during which it lets the line float up. Each phase has its own 9-bit length, counted in ticks of a prescaled clock. A tick is either every input clock or every second input clock.

The low phase is timed from the cycle the pull-down starts. The high phase is timed only once the synchronized SCL input has been seen high. Rise time therefore does not shorten it, and a slave that holds SCL low lengthens it. Each 9-bit length is given as an 8-bit count plus an extension bit, and the extension bits live in a shared configuration byte. The block also gives the bit engine two strobes: one where SDA may change (start of low) and one where SDA should be sampled (middle of high).

Top module: `scl_period_gen`

## Requirements
- R1: After a synchronous reset, scl_drive_low, sda_change_stb and sda_sample_stb are all 0.
- R2: Unless enable and active are both 1, SCL is released and no strobe pulses. Dropping either input releases SCL at the next clock edge.
- R3: A low phase lasts exactly L ticks, where L is the effective low count, and begins on the first cycle scl_drive_low is 1. A tick is one clock when div2=0 and two clocks when div2=1.
- R4: High-phase counting starts only after the synchronized SCL input is seen high. With SYNC_STAGES=2, a released interval lasts H ticks plus 3 clocks, where H is the effective high count.
- R5: If a slave holds SCL low after release, the released interval grows by exactly the number of clocks the line is held.
- R6: Bit 8 of the low count is ext_cfg[7] and bit 8 of the high count is ext_cfg[6]. Bits 5..0 of ext_cfg have no effect.
- R7: A count value of 0 behaves as 1 tick.
- R8: sda_change_stb is a one-clock pulse on the first cycle of every low phase and at no other time.
- R9: sda_sample_stb is a one-clock pulse in each high phase. It falls on the first cycle after floor(H/2) ticks of high counting have elapsed, which is released-interval cycle 4+floor(H/2) (div2=0) or 4+2*floor(H/2) (div2=1), counted from 1 and delayed further by any stretch.
- R10: Count inputs are captured when a phase starts. A change made during a phase first affects the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enabled |
| active | input | 1 | Transfer in progress |
| div2 | input | 1 | 1: tick every second clock; 0: every clock |
| low_count | input | 8 | Low-phase count, bits 7..0 |
| high_count | input | 8 | High-phase count, bits 7..0 |
| ext_cfg | input | 8 | Configuration byte; bit 7 and bit 6 extend the counts |
| scl_in | input | 1 | Observed SCL line level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_change_stb | output | 1 | Start-of-low strobe |
| sda_sample_stb | output | 1 | Mid-high strobe |

## Verification
The assertions assume that scl_in is never high while scl_drive_low is 1. In other words, they assume an open-drain line that only other devices can hold low. The stimulus respects this by modelling the line as the complement of the drive, ANDed with a bounded slave hold that starts only after release. The assertions also assume that count inputs are steady except at the moments the bench chooses. Every configuration change is made on a falling clock edge, while a phase is known to be in progress.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic div2,
  input  logic restart,
  output logic tick
);
  logic phase_q;

  // Restart aligns the first tick of a phase: with div2 the first tick is
  // the second cycle after the phase load.
  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= 1'b0;
    else                phase_q <= ~phase_q;
  end

  assign tick = ~div2 | phase_q;
endmodule

// File: rtl/scl_count_sel.sv
module scl_count_sel #(
  parameter int REG_W        = 8,
  parameter int LOW_EXT_POS  = 7,
  parameter int HIGH_EXT_POS = 6,
  localparam int COUNT_W     = REG_W + 1
) (
  input  logic [REG_W-1:0]   low_reg,
  input  logic [REG_W-1:0]   high_reg,
  input  logic [REG_W-1:0]   ext_reg,
  output logic [COUNT_W-1:0] low_eff,
  output logic [COUNT_W-1:0] high_eff
);
  logic [COUNT_W-1:0] low_raw, high_raw;

  assign low_raw  = {ext_reg[LOW_EXT_POS],  low_reg};
  assign high_raw = {ext_reg[HIGH_EXT_POS], high_reg};

  // A zero count would stall the phase; it is promoted to one tick.
  assign low_eff  = (low_raw  == '0) ? COUNT_W'(1) : low_raw;
  assign high_eff = (high_raw == '0) ? COUNT_W'(1) : high_raw;
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int COUNT_W    = REG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             active,
  input  logic             div2,
  input  logic [REG_W-1:0] low_count,
  input  logic [REG_W-1:0] high_count,
  input  logic [REG_W-1:0] ext_cfg,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             sda_change_stb,
  output logic             sda_sample_stb
);
  scl_phase_e         state_q;
  logic [COUNT_W-1:0] remain_q;
  logic [COUNT_W-1:0] mid_q;
  logic               seen_low_q;
  logic               run;
  logic               scl_s;
  logic               tick;
  logic               start_low;
  logic               start_high;
  logic [COUNT_W-1:0] low_eff, high_eff;
  logic [COUNT_W-1:0] remain_dec;

  assign run        = enable & active;
  assign remain_dec = remain_q - COUNT_W'(1);

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (scl_in),
    .q_sync  (scl_s)
  );

  scl_count_sel #(.REG_W(REG_W)) u_sel (
    .low_reg  (low_count),
    .high_reg (high_count),
    .ext_reg  (ext_cfg),
    .low_eff  (low_eff),
    .high_eff (high_eff)
  );

  always_comb begin
    start_low  = 1'b0;
    start_high = 1'b0;
    if (run) begin
      unique case (state_q)
        PH_IDLE: start_low  = 1'b1;
        PH_HIGH: start_low  = tick && (remain_q == COUNT_W'(1));
        PH_WAIT: start_high = seen_low_q && scl_s;
        default: ;
      endcase
    end
  end

  scl_tick_gen u_tick (
    .clk     (clk),
    .rst     (rst),
    .div2    (div2),
    .restart (start_low | start_high),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= PH_IDLE;
      remain_q       <= '0;
      mid_q          <= '0;
      seen_low_q     <= 1'b0;
      scl_drive_low  <= 1'b0;
      sda_change_stb <= 1'b0;
      sda_sample_stb <= 1'b0;
    end else begin
      sda_change_stb <= 1'b0;
      sda_sample_stb <= 1'b0;
      if (!run) begin
        state_q       <= PH_IDLE;
        scl_drive_low <= 1'b0;
        seen_low_q    <= 1'b0;
      end else if (start_low) begin
        state_q        <= PH_LOW;
        scl_drive_low  <= 1'b1;
        remain_q       <= low_eff;
        sda_change_stb <= 1'b1;
        seen_low_q     <= 1'b0;
      end else if (start_high) begin
        state_q        <= PH_HIGH;
        remain_q       <= high_eff;
        mid_q          <= high_eff - (high_eff >> 1);
        sda_sample_stb <= (high_eff == COUNT_W'(1));
      end else begin
        unique case (state_q)
          PH_LOW: begin
            if (!scl_s) seen_low_q <= 1'b1;
            if (tick) begin
              if (remain_q == COUNT_W'(1)) begin
                state_q       <= PH_WAIT;
                scl_drive_low <= 1'b0;
              end else begin
                remain_q <= remain_dec;
              end
            end
          end
          PH_WAIT: begin
            if (!scl_s) seen_low_q <= 1'b1;
          end
          PH_HIGH: begin
            if (tick) begin
              remain_q       <= remain_dec;
              sda_sample_stb <= (remain_dec == mid_q);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic active,
  input logic scl_drive_low,
  input logic sda_change_stb,
  input logic sda_sample_stb
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!enable || !active) |=> (!scl_drive_low && !sda_change_stb && !sda_sample_stb)); // R2

  AST_FALL_HAS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> sda_change_stb); // R8

  AST_CHANGE_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    sda_change_stb |-> (scl_drive_low && !$past(scl_drive_low))); // R8

  AST_SAMPLE_WHILE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    sda_sample_stb |-> !scl_drive_low); // R9

  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sda_sample_stb |=> !sda_sample_stb); // R9

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    !(sda_sample_stb && sda_change_stb)); // R8
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .enable         (enable),
  .active         (active),
  .scl_drive_low  (scl_drive_low),
  .sda_change_stb (sda_change_stb),
  .sda_sample_stb (sda_sample_stb)
);

// File: tb/tb_scl_period_gen.sv
module tb_scl_period_gen;
  localparam int SYNC = 2;

  typedef struct {
    bit is_low;
    int len;
    int spos;
    string req;
  } seg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, active = 1'b0, div2 = 1'b0;
  logic [7:0] low_count = 8'd1, high_count = 8'd1, ext_cfg = 8'd0;
  logic hold = 1'b0;
  logic scl_in;
  logic scl_drive_low, sda_change_stb, sda_sample_stb;

  int tests = 0, fails = 0;
  int stretch_n = 0;
  int hcnt = 0;
  bit mon_on = 0;
  seg_t exp_q[$];

  always #4 clk = ~clk;

  assign scl_in = !scl_drive_low && !hold;

  scl_period_gen dut (
    .clk(clk), .rst(rst), .enable(enable), .active(active), .div2(div2),
    .low_count(low_count), .high_count(high_count), .ext_cfg(ext_cfg),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sda_change_stb(sda_change_stb), .sda_sample_stb(sda_sample_stb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Slave clock stretching model: hold the line after each release.
  bit prev_drv = 0;
  always @(negedge clk) begin
    if (hcnt > 0) begin
      hcnt--;
      hold = (hcnt > 0);
    end
    if (prev_drv && !scl_drive_low && stretch_n > 0) begin
      hold = 1'b1;
      hcnt = stretch_n;
    end
    prev_drv = scl_drive_low;
  end

  // Monitor: measures segments of drive/release and compares with the queue.
  bit seg_valid = 0, cur_kind = 0;
  int seg_len = 0, n_chg = 0, n_smp = 0, chg_pos = 0, smp_pos = 0;
  always @(negedge clk) begin
    if (!mon_on) begin
      seg_valid = 0;
      cur_kind = 0;
    end else begin
      if (scl_drive_low != cur_kind) begin
        if (seg_valid) begin
          if (exp_q.size() == 0) begin
            check(0, "R3", "unexpected segment", seg_len, 0);
          end else begin
            seg_t e;
            e = exp_q.pop_front();
            check(e.is_low == cur_kind, e.req, "segment kind", cur_kind, e.is_low);
            check(seg_len == e.len, e.req, "segment length", seg_len, e.len);
            if (cur_kind) begin
              check(n_chg == 1 && chg_pos == 1, "R8", "change strobe pos", chg_pos, 1);
              check(n_smp == 0, "R9", "sample strobe in low", n_smp, 0);
            end else begin
              check(n_smp == 1 && smp_pos == e.spos, "R9", "sample strobe pos", smp_pos, e.spos);
              check(n_chg == 0, "R8", "change strobe in release", n_chg, 0);
            end
          end
        end
        seg_valid = 1;
        cur_kind = scl_drive_low;
        seg_len = 0; n_chg = 0; n_smp = 0; chg_pos = 0; smp_pos = 0;
      end
      seg_len++;
      if (sda_change_stb) begin n_chg++; if (chg_pos == 0) chg_pos = seg_len; end
      if (sda_sample_stb) begin n_smp++; if (smp_pos == 0) smp_pos = seg_len; end
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic push_period(input int l, input int h, input bit d2,
                             input int s, input string req);
    int w;
    seg_t a, b;
    w = d2 ? 2 : 1;
    a.is_low = 1; a.len = w * eff(l); a.spos = 0; a.req = req;
    b.is_low = 0; b.len = w * eff(h) + SYNC + 1 + s;
    b.spos = SYNC + 2 + w * (eff(h) / 2) + s; b.req = req;
    exp_q.push_back(a);
    exp_q.push_back(b);
  endtask

  task automatic config_set(input int l9, input int h9, input bit d2, input logic [7:0] ext);
    @(negedge clk); #1;
    low_count = l9[7:0];
    high_count = h9[7:0];
    ext_cfg = ext;
    div2 = d2;
  endtask

  task automatic wait_drain_and_stop(input string req);
    while (exp_q.size() != 0) begin
      @(negedge clk); #1;
    end
    mon_on = 0;
    active = 1'b0;
    @(negedge clk); #1;
    check(scl_drive_low == 1'b0, "R2", "release after active drop", scl_drive_low, 0);
    repeat (4) @(negedge clk);
    #1;
    stretch_n = 0;
    hold = 1'b0;
    hcnt = 0;
  endtask

  task automatic run_case(input int l, input int h, input bit d2, input logic [7:0] ext,
                          input int s, input int n, input string req);
    int lt, ht;
    lt = {ext[7], l[7:0]};
    ht = {ext[6], h[7:0]};
    config_set(l, h, d2, ext);
    stretch_n = s;
    for (int i = 0; i < n; i++) push_period(lt, ht, d2, s, req);
    mon_on = 1;
    active = 1'b1;
    wait_drain_and_stop(req);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(0, "R3", "watchdog expired", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl_drive_low == 0 && sda_change_stb == 0 && sda_sample_stb == 0,
          "R1", "outputs in reset", {scl_drive_low, sda_change_stb, sda_sample_stb}, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check(scl_drive_low == 0 && sda_change_stb == 0 && sda_sample_stb == 0,
          "R1", "outputs after reset", {scl_drive_low, sda_change_stb, sda_sample_stb}, 0);

    // R2: transfer active but controller disabled -> nothing happens
    begin
      int seen;
      seen = 0;
      active = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (scl_drive_low || sda_change_stb || sda_sample_stb) seen++;
      end
      check(seen == 0, "R2", "activity while disabled", seen, 0);
      active = 1'b0;
      enable = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (scl_drive_low || sda_change_stb || sda_sample_stb) seen++;
      end
      check(seen == 0, "R2", "activity while no transfer", seen, 0);
    end

    run_case(3, 2, 1'b0, 8'h00, 0, 3, "R3");            // R3, R4 single-clock tick
    run_case(2, 3, 1'b1, 8'h00, 0, 3, "R3");            // R3 halved tick
    run_case(5, 4, 1'b0, 8'h00, 0, 2, "R4");            // R4 release latency
    run_case(0, 0, 1'b0, 8'h00, 0, 3, "R7");            // R7 zero counts
    run_case(0, 0, 1'b1, 8'h00, 0, 2, "R7");            // R7 with div2
    run_case(5, 4, 1'b0, 8'h3F, 0, 2, "R6");            // R6 low ext bits ignored
    run_case(16, 2, 1'b0, 8'h80, 0, 1, "R6");           // R6 low count bit 8
    run_case(0, 0, 1'b0, 8'hFF, 0, 1, "R6");            // R6 both extensions: 256/256
    run_case(2, 2, 1'b0, 8'h00, 5, 3, "R5");            // R5 stretched
    run_case(3, 1, 1'b1, 8'h00, 3, 2, "R5");            // R5 stretched, div2

    // R10: counts change during the second low phase
    begin
      int nchg;
      config_set(4, 3, 1'b0, 8'h00);
      push_period(4, 3, 1'b0, 0, "R10");
      push_period(4, 5, 1'b0, 0, "R10");
      push_period(6, 5, 1'b0, 0, "R10");
      mon_on = 1;
      active = 1'b1;
      nchg = 0;
      while (nchg < 2) begin
        @(negedge clk); #1;
        if (sda_change_stb) nchg++;
      end
      low_count = 8'd6;
      high_count = 8'd5;
      wait_drain_and_stop("R10");
    end

    // R2: drop enable in the middle of a low phase
    config_set(20, 2, 1'b0, 8'h00);
    active = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(scl_drive_low == 1'b1, "R3", "low in progress", scl_drive_low, 1);
    enable = 1'b0;
    @(negedge clk); #1;
    check(scl_drive_low == 1'b0, "R2", "release on enable drop", scl_drive_low, 0);
    active = 1'b0;

    finish_run();
  end
endmodule